// File: doc/BRIEF.md
# PLL output frequency decoder

This block works out the frequency one clock domain runs at, given how that domain was configured. It takes a boot-configuration word, the domain's divider control register, its PLL register and four candidate base frequencies. On a start strobe it captures all of these. It picks the base clock through a two-bit source field, applies the bypass, PLL-off, dual-divide and multiplier rules, and divides the result by the product of the pre- and post-dividers. The integer frequency then appears on the output together with a one-cycle done pulse.

The division is sequential, using one restoring step per clock. A result therefore takes a fixed number of cycles, and the block ignores new requests until that result has been published. Software or a boot sequencer can query each domain in turn by changing the source-field offset and the register values between requests.

Top module: `pll_freq_decoder`

## Requirements
- R1: The base clock is chosen by the two boot-word bits at positions srcOffset+1 and srcOffset, where srcOffset is from 0 to 30. The field values are 0 for busFreq, 1 for refFreq, 2 for xtalFreq and 3 for cpuFreq.
- R2: The divisor is (divCtrl[20:16]+1) times (divCtrl[4:0]+1). All other bits of divCtrl have no effect.
- R3: When boot-word bit 5 is set, the result is base divided by the divisor, whatever the PLL register holds.
- R4: When bit 5 is clear and pllReg[0] is 0, the numerator is base>>1, or base>>2 when the multiplier is 16. The multiplier is pllReg[15:12]+1.
- R5: When bit 5 is clear and pllReg[0], pllReg[1] and pllReg[11] are all 1, the numerator depends on the multiplier. An odd multiplier gives (base*mul)>>1. An even multiplier gives (base*(mul-1))>>2.
- R6: In every other case, a multiplier of 16 makes the numerator equal to base, and any other multiplier makes it base*mul.
- R7: The numerator is formed exactly in 40 bits. Division truncates, and freqOut carries the low 32 bits of the quotient.
- R8: done is high for exactly one cycle, the cycle that follows the 41st rising edge after the edge that samples start. freqOut changes only at that edge and holds its value until the next done.
- R9: A start pulse that arrives while a request is in flight is ignored. Input changes during that time do not alter the result.
- R10: After reset, freqOut is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode; all other inputs are captured on this edge |
| bootWord | input | 32 | Boot configuration word (source fields, bypass bit) |
| srcOffset | input | 5 | Bit offset of the 2-bit source field |
| divCtrl | input | 32 | Divider control register of the domain |
| pllReg | input | 32 | PLL register of the domain |
| busFreq | input | 32 | Candidate base frequency, source code 0 |
| refFreq | input | 32 | Candidate base frequency, source code 1 |
| xtalFreq | input | 32 | Candidate base frequency, source code 2 |
| cpuFreq | input | 32 | Candidate base frequency, source code 3 |
| freqOut | output | 32 | Decoded frequency |
| done | output | 1 | One-cycle pulse when freqOut is updated |

## Verification
The bench targets the priority between bypass, PLL-off and dual-divide. A design that ranked these wrongly would return a multiplied value when a bypassed one is expected. It checks the multiplier value 16, where a wrong design would shift by one instead of two or multiply by 16 instead of passing base through. It also checks the odd and even branches of the dual-divide path, where swapping the branches changes the result by roughly a factor of two.

Other cases cover the source field at offsets 0 and 30, junk bits in the divider register, and 40-bit products whose low 32 bits wrap. A start pulse with different operands is injected during a request: a design that restarts or re-samples would publish the wrong value or a late done.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
    logic publish;
  } pfd_strobe_t;

  localparam int BYPASS_BIT = 5;
  localparam int PLL_ON_BIT = 0;
  localparam int DUAL_HI_BIT = 11;
  localparam int DUAL_LO_BIT = 1;
  localparam int MUL_LSB = 12;
  localparam int PRE_LSB = 16;
  localparam int POST_LSB = 0;
endpackage

// File: rtl/pfd_numerator.sv
module pfd_numerator #(
  parameter int FREQ_W = 32,
  parameter int PROD_W = 40,
  parameter int MUL_W = 4,
  parameter int OFS_W = 5
) (
  input  logic [31:0]       bootWord,
  input  logic [OFS_W-1:0]  srcOffset,
  input  logic [31:0]       pllReg,
  input  logic [FREQ_W-1:0] busFreq,
  input  logic [FREQ_W-1:0] refFreq,
  input  logic [FREQ_W-1:0] xtalFreq,
  input  logic [FREQ_W-1:0] cpuFreq,
  output logic [PROD_W-1:0] numerator
);
  import pfd_pkg::*;

  localparam int NUM_SRC = 4;
  localparam logic [MUL_W:0] MUL_MAX = (MUL_W+1)'(1 << MUL_W);

  logic [FREQ_W-1:0] candidate [NUM_SRC];
  logic [31:0] bootShifted;
  logic [1:0] srcSel;
  logic [FREQ_W-1:0] baseFreq;
  logic [MUL_W:0] mulVal;
  logic mulIsMax;
  logic [PROD_W-1:0] baseWide, prodFull, prodLess;

  assign candidate[0] = busFreq;
  assign candidate[1] = refFreq;
  assign candidate[2] = xtalFreq;
  assign candidate[3] = cpuFreq;

  assign bootShifted = bootWord >> srcOffset;
  assign srcSel = bootShifted[1:0];
  assign baseFreq = candidate[srcSel];

  assign mulVal = {1'b0, pllReg[MUL_LSB +: MUL_W]} + 1'b1;
  assign mulIsMax = (mulVal == MUL_MAX);
  assign baseWide = PROD_W'(baseFreq);
  assign prodFull = baseWide * PROD_W'(mulVal);
  assign prodLess = baseWide * PROD_W'(mulVal - 1'b1);

  logic unusedPll;
  assign unusedPll = ^{pllReg[31:MUL_LSB+MUL_W], pllReg[MUL_LSB-1:DUAL_HI_BIT+1],
                       pllReg[DUAL_HI_BIT-1:DUAL_LO_BIT+1], bootShifted[31:2]};

  always_comb begin
    if (bootWord[BYPASS_BIT]) begin
      numerator = baseWide;
    end else if (!pllReg[PLL_ON_BIT]) begin
      numerator = mulIsMax ? (baseWide >> 2) : (baseWide >> 1);
    end else if (pllReg[DUAL_HI_BIT] && pllReg[DUAL_LO_BIT]) begin
      numerator = mulVal[0] ? (prodFull >> 1) : (prodLess >> 2);
    end else if (mulIsMax) begin
      numerator = baseWide;
    end else begin
      numerator = prodFull;
    end
  end
endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath #(
  parameter int FREQ_W = 32,
  parameter int PROD_W = 40,
  parameter int FIELD_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pfd_pkg::pfd_strobe_t  strobe,
  input  logic [PROD_W-1:0]     numerator,
  input  logic [31:0]           divCtrl,
  output logic [FREQ_W-1:0]     freqOut
);
  import pfd_pkg::*;

  localparam int DIV_W = 2*FIELD_W + 1;

  logic [FIELD_W:0] preVal, postVal;
  logic [DIV_W-1:0] divisorNext;
  logic [DIV_W-1:0] divReg, remReg;
  logic [PROD_W-1:0] quoReg;
  logic [DIV_W:0] trial, diff;
  logic fits;

  assign preVal = {1'b0, divCtrl[PRE_LSB +: FIELD_W]} + 1'b1;
  assign postVal = {1'b0, divCtrl[POST_LSB +: FIELD_W]} + 1'b1;
  assign divisorNext = DIV_W'(preVal) * DIV_W'(postVal);

  logic unusedCtrl;
  assign unusedCtrl = ^{divCtrl[31:PRE_LSB+FIELD_W], divCtrl[PRE_LSB-1:POST_LSB+FIELD_W]};

  assign trial = {remReg, quoReg[PROD_W-1]};
  assign fits = (trial >= {1'b0, divReg});
  assign diff = trial - {1'b0, divReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= DIV_W'(1);
      remReg <= '0;
      quoReg <= '0;
      freqOut <= '0;
    end else begin
      if (strobe.load) begin
        divReg <= divisorNext;
        remReg <= '0;
        quoReg <= numerator;
      end else if (strobe.step) begin
        remReg <= fits ? diff[DIV_W-1:0] : trial[DIV_W-1:0];
        quoReg <= {quoReg[PROD_W-2:0], fits};
      end
      if (strobe.publish) begin
        freqOut <= quoReg[FREQ_W-1:0];
      end
    end
  end

  // restoring invariant: partial remainder stays below the divisor (R7)
  p_rem_below_divisor_r7: assert property (@(posedge clk) disable iff (!rstN)
    remReg < divReg);

  // the divisor never changes while the steps run (R9)
  p_divisor_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(divReg));
endmodule

// File: rtl/pfd_control.sv
module pfd_control #(
  parameter int PROD_W = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output pfd_pkg::pfd_strobe_t strobe,
  output logic                 done
);
  localparam int CNT_W = $clog2(PROD_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(PROD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} state_t;
  state_t state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe.load = (state == S_IDLE) && start;
    strobe.step = (state == S_DIV);
    strobe.publish = (state == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      stepCnt <= '0;
      done <= 1'b0;
    end else begin
      done <= (state == S_FIN);
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_DIV;
            stepCnt <= '0;
          end
        end
        S_DIV: begin
          if (stepCnt == LAST_STEP) begin
            state <= S_FIN;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_fin_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DIV && stepCnt == LAST_STEP) |=> (state == S_FIN));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DIV && stepCnt != LAST_STEP) |=> (state == S_DIV));
endmodule

// File: rtl/pll_freq_decoder.sv
module pll_freq_decoder #(
  parameter int FREQ_W = 32,
  parameter int PROD_W = 40,
  parameter int FIELD_W = 5,
  parameter int MUL_W = 4,
  parameter int OFS_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [31:0]       bootWord,
  input  logic [OFS_W-1:0]  srcOffset,
  input  logic [31:0]       divCtrl,
  input  logic [31:0]       pllReg,
  input  logic [FREQ_W-1:0] busFreq,
  input  logic [FREQ_W-1:0] refFreq,
  input  logic [FREQ_W-1:0] xtalFreq,
  input  logic [FREQ_W-1:0] cpuFreq,
  output logic [FREQ_W-1:0] freqOut,
  output logic              done
);
  pfd_pkg::pfd_strobe_t strobe;
  logic [PROD_W-1:0] numerator;

  pfd_numerator #(.FREQ_W(FREQ_W), .PROD_W(PROD_W), .MUL_W(MUL_W), .OFS_W(OFS_W)) u_num (
    .bootWord(bootWord), .srcOffset(srcOffset), .pllReg(pllReg),
    .busFreq(busFreq), .refFreq(refFreq), .xtalFreq(xtalFreq), .cpuFreq(cpuFreq),
    .numerator(numerator)
  );

  pfd_datapath #(.FREQ_W(FREQ_W), .PROD_W(PROD_W), .FIELD_W(FIELD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .numerator(numerator),
    .divCtrl(divCtrl), .freqOut(freqOut)
  );

  pfd_control #(.PROD_W(PROD_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .strobe(strobe), .done(done)
  );

  // output moves only together with the done pulse (R8)
  p_out_moves_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqOut) |-> done);
endmodule

// File: tb/test_pll_freq_decoder.sv
module test_pll_freq_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] bootWord = '0, divCtrl = '0, pllReg = '0;
  logic [4:0] srcOffset = '0;
  logic [31:0] busFreq = '0, refFreq = '0, xtalFreq = '0, cpuFreq = '0;
  logic [31:0] freqOut;
  logic done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pll_freq_decoder i_pll_freq_decoder (
    .clk(clk), .rstN(rstN), .start(start), .bootWord(bootWord), .srcOffset(srcOffset),
    .divCtrl(divCtrl), .pllReg(pllReg), .busFreq(busFreq), .refFreq(refFreq),
    .xtalFreq(xtalFreq), .cpuFreq(cpuFreq), .freqOut(freqOut), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d exp<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] bw, logic [4:0] ofs, logic [31:0] dc,
      logic [31:0] pr, logic [31:0] f0, logic [31:0] f1, logic [31:0] f2, logic [31:0] f3);
    longint unsigned base, num, dv;
    int sel, mul;
    sel = int'((bw >> ofs) & 32'd3);
    case (sel)
      0: base = longint'(f0);
      1: base = longint'(f1);
      2: base = longint'(f2);
      default: base = longint'(f3);
    endcase
    mul = int'(pr[15:12]) + 1;
    dv = longint'((int'(dc[20:16]) + 1) * (int'(dc[4:0]) + 1));
    if (bw[5]) num = base;
    else if (!pr[0]) num = (mul == 16) ? base / 4 : base / 2;
    else if (pr[11] && pr[1]) num = (mul % 2 == 1) ? (base * longint'(mul)) / 2
                                                   : (base * longint'(mul - 1)) / 4;
    else if (mul == 16) num = base;
    else num = base * longint'(mul);
    return 32'(num / dv);
  endfunction

  task automatic runCase(string req, logic [31:0] bw, logic [4:0] ofs, logic [31:0] dc,
      logic [31:0] pr, logic [31:0] f0, logic [31:0] f1, logic [31:0] f2, logic [31:0] f3,
      bit poke);
    logic [31:0] expv;
    int cnt;
    expv = model(bw, ofs, dc, pr, f0, f1, f2, f3);
    @(negedge clk);
    bootWord = bw; srcOffset = ofs; divCtrl = dc; pllReg = pr;
    busFreq = f0; refFreq = f1; xtalFreq = f2; cpuFreq = f3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 200) begin
      if (poke && cnt == 10) begin
        start = 1'b1;
        bootWord = ~bw; divCtrl = 32'h0003_0002; pllReg = ~pr;
        busFreq = 32'd7; refFreq = 32'd9; xtalFreq = 32'd11; cpuFreq = 32'd13;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check(freqOut == expv, req, longint'(freqOut), longint'(expv));
    check(cnt == 42, {"R8 latency ", req}, cnt, 42);
    @(negedge clk);
    check(done == 1'b0, "R8 single pulse", longint'(done), 0);
    if (poke) begin
      // no second result may follow the ignored start
      for (int k = 0; k < 45; k++) begin
        @(negedge clk);
        if (done || freqOut != expv) begin
          check(1'b0, "R9 late restart", longint'(freqOut), longint'(expv));
          break;
        end
      end
    end
  endtask

  initial begin
    logic [31:0] holdVal;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(freqOut == 32'd0, "R10 freqOut reset", longint'(freqOut), 0);
    check(done == 1'b0, "R10 done reset", longint'(done), 0);
    rstN = 1'b1;

    // R1: each source at offset 14 with bypass and unit divisor
    for (int s = 0; s < 4; s++)
      runCase("R1 source", 32'h20 | (32'(s) << 14), 5'd14, 32'h0, 32'h0,
              32'd1000, 32'd2000, 32'd3000, 32'd4000, 0);
    runCase("R1 offset0", 32'h0000_0022, 5'd0, 32'h0, 32'h0, 32'd11, 32'd22, 32'd33, 32'd44, 0);
    runCase("R1 offset30", 32'hC000_0020, 5'd30, 32'h0, 32'h0, 32'd11, 32'd22, 32'd33, 32'd44, 0);
    // R2: junk bits in divider register, divisor 3*5
    runCase("R2 divisor", 32'h20, 5'd0, 32'hFFE2_FFE4, 32'h0, 32'd150000000, 32'd1, 32'd1, 32'd1, 0);
    // R3: bypass wins over any PLL setting
    runCase("R3 bypass", 32'h20, 5'd0, 32'h0001_0001, 32'hFFFF_FFFF, 32'd125000000, 32'd1, 32'd1, 32'd1, 0);
    // R4: PLL off, mul 16 and mul 5
    runCase("R4 off mul16", 32'h0, 5'd0, 32'h0, 32'h0000_F802, 32'd100000003, 32'd1, 32'd1, 32'd1, 0);
    runCase("R4 off mul5", 32'h0, 5'd0, 32'h0, 32'h0000_4000, 32'd100000003, 32'd1, 32'd1, 32'd1, 0);
    // R5: dual divide odd, even, mul 16
    runCase("R5 odd", 32'h0, 5'd0, 32'h0, 32'h0000_6803, 32'd25000001, 32'd1, 32'd1, 32'd1, 0);
    runCase("R5 even", 32'h0, 5'd0, 32'h0, 32'h0000_5803, 32'd25000001, 32'd1, 32'd1, 32'd1, 0);
    runCase("R5 mul16", 32'h0, 5'd0, 32'h0, 32'h0000_F803, 32'd25000001, 32'd1, 32'd1, 32'd1, 0);
    // R6: normal mode
    runCase("R6 mul16", 32'h0, 5'd0, 32'h0000_0001, 32'h0000_F001, 32'd48000000, 32'd1, 32'd1, 32'd1, 0);
    runCase("R6 mul7", 32'h0, 5'd0, 32'h0002_0004, 32'h0000_6801, 32'd35328000, 32'd1, 32'd1, 32'd1, 0);
    // R7: wide product wraps to low 32 bits, and truncating divide
    runCase("R7 wide", 32'h0, 5'd0, 32'h0, 32'h0000_E001, 32'hFFFF_FFFF, 32'd1, 32'd1, 32'd1, 0);
    runCase("R7 trunc", 32'h20, 5'd0, 32'h0000_0006, 32'h0, 32'd100, 32'd1, 32'd1, 32'd1, 0);
    runCase("R7 maxdiv", 32'h0, 5'd0, 32'h001F_001F, 32'h0000_E001, 32'hFFFF_FFFF, 32'd1, 32'd1, 32'd1, 0);
    // R9: start during a request is ignored
    runCase("R9 busy start", 32'h0, 5'd0, 32'h0001_0000, 32'h0000_4001, 32'd40000000, 32'd1, 32'd1, 32'd1, 1);
    // R8: output holds with no start while inputs move
    holdVal = freqOut;
    @(negedge clk);
    busFreq = 32'd5; pllReg = 32'hFFFF; bootWord = 32'h20;
    repeat (6) @(negedge clk);
    check(freqOut == holdVal && !done, "R8 hold", longint'(freqOut), longint'(holdVal));

    // random mix across all modes
    for (int n = 0; n < 60; n++) begin
      logic [31:0] rb, rd, rp;
      logic [4:0] ro;
      rb = $urandom();
      ro = 5'($urandom_range(30, 0));
      rd = $urandom();
      rp = $urandom();
      if (n % 4 == 0) rp = rp | 32'h0000_0803;
      if (n % 3 == 0) rb = rb & ~32'h20;
      runCase("R6 random", rb, ro, rd, rp, $urandom(), $urandom(), $urandom(), $urandom(), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule